// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block sits beside a receive byte stream and decides, frame by frame, whether the frame is kept or dropped. It looks only at the first six bytes of each frame, which hold the destination address. A frame is kept when the filter is in promiscuous mode, or when the address passes one of four checks: an exact match on the station's own unicast address, a unicast hash lookup, a group hash lookup, or the broadcast policy. When a frame ends, the filter raises a one-cycle flush request for the receive FIFO if the frame was refused or was too short. No software action is needed.

Bytes arrive as a valid/ready stream, with start-of-frame and end-of-frame markers on the first and last beat. The filter observes the stream and never stalls it: `in_ready` is always high, so a beat is taken on every clock edge where `in_valid` is high. An upstream source must keep `in_data` and the markers stable only while `in_valid` is high. The configuration inputs are plain levels. They must not change between the start of a frame and the cycle after its end.

Top module: `rx_dst_filter`

## Requirements
- R1: `in_ready` is high whenever reset is released, and a beat is taken on each edge with `in_valid` high. Beats that come after an end-of-frame beat and before the next start-of-frame beat have no effect on `dec_valid`, `dec_accept` or `flush`.
- R2: The first address byte received is the most significant byte, so it lines up with `cfg_unit_addr[47:40]`. Bit 0 of that first byte is the group flag: 1 means group, 0 means individual.
- R3: The broadcast address (all 48 bits set) is refused when `cfg_bcast_reject` is 1. It is accepted when `cfg_bcast_reject` is 0, whatever the hash tables hold.
- R4: An individual address equal to `cfg_unit_addr` is accepted.
- R5: An individual address that is not equal to `cfg_unit_addr` is accepted only if bit `h` of `cfg_uni_hash` is set, where `h` is the hash index of R11.
- R6: A group address other than broadcast is accepted only if bit `h` of `cfg_grp_hash` is set. `cfg_uni_hash` plays no part for such an address.
- R7: When `cfg_promisc` is 1, every frame with at least six bytes is accepted. This overrides R3.
- R8: `dec_valid` goes high one clock after the edge that takes the sixth byte of a frame. From then on, `dec_valid` and `dec_accept` hold their values until the edge that takes the next start-of-frame beat, where both clear. `dec_accept` is low whenever `dec_valid` is low.
- R9: `flush` is a single-cycle pulse one clock after the end-of-frame beat. It is raised when the frame's address was refused. It is never high at any other time.
- R10: A frame of fewer than 64 bytes, counted from the start beat through the end beat inclusive, raises `flush` even if its address was accepted. A frame of fewer than six bytes gives no decision (`dec_valid` stays low) and always raises `flush`.
- R11: The hash index `h` is bits 31:26 of a 32-bit CRC register. The register starts at all ones and takes the six address bytes in arrival order, each byte least significant bit first, using the reflected Ethernet polynomial 0xEDB88320 with no final inversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Stream beat present |
| in_ready | output | 1 | Always high: the filter never stalls the stream |
| in_data | input | 8 | Stream byte |
| in_sof | input | 1 | Beat is the first byte of a frame |
| in_eof | input | 1 | Beat is the last byte of a frame |
| cfg_promisc | input | 1 | Accept every frame |
| cfg_bcast_reject | input | 1 | 1 refuses broadcast frames, 0 accepts them |
| cfg_unit_addr | input | 48 | Station unicast address, first byte in bits 47:40 |
| cfg_uni_hash | input | 64 | Hash table for individual addresses |
| cfg_grp_hash | input | 64 | Hash table for group addresses |
| dec_valid | output | 1 | Address decision available for the current frame |
| dec_accept | output | 1 | Decision: frame accepted |
| flush | output | 1 | One-cycle request to drop the frame just ended |

## Verification
Any fault in the byte counter shows up within one frame. It either moves the `dec_valid` rise away from the cycle after the sixth byte, or it puts `flush` on the wrong side of the 63/64-byte boundary. A fault in the address shift register or the CRC register picks the wrong exact-match result or the wrong hash bit. This is exposed one clock after the sixth byte by hash tables that have every bit set except the computed index, or only that index set. A stuck frame-tracking flag shows as a spurious `flush` or a changed decision while bytes arrive outside any frame.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;

  typedef enum logic [1:0] {
    KIND_UNI   = 2'd0,
    KIND_GRP   = 2'd1,
    KIND_BCAST = 2'd2
  } addr_kind_e;

  // Reflected CRC-32: one byte, least significant bit first.
  function automatic logic [31:0] crc_step_byte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY_REFL;
      else             r = r >> 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/rxf_beat_track.sv
module rxf_beat_track #(
  parameter int ADDR_BYTES = 6,
  parameter int MIN_LEN    = 64,
  localparam int CNT_W     = $clog2(MIN_LEN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_sof,
  input  logic in_eof,
  output logic take,
  output logic first,
  output logic addr_beat,
  output logic last_addr_beat,
  output logic runt_end
);
  logic             in_frame_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_after;
  logic [CNT_W-1:0] pos;

  assign take  = in_valid & (in_sof | in_frame_q);
  assign first = take & in_sof;
  // byte position of the current beat within its frame
  assign pos   = in_sof ? '0 : cnt_q;
  assign cnt_after = in_sof ? CNT_W'(1)
                   : (cnt_q == CNT_W'(MIN_LEN)) ? cnt_q : cnt_q + CNT_W'(1);

  assign addr_beat      = take & (pos < CNT_W'(ADDR_BYTES));
  assign last_addr_beat = take & (pos == CNT_W'(ADDR_BYTES - 1));
  assign runt_end       = cnt_after < CNT_W'(MIN_LEN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame_q <= 1'b0;
      cnt_q      <= '0;
    end else if (take) begin
      in_frame_q <= ~in_eof;
      cnt_q      <= cnt_after;
    end
  end
endmodule

// File: rtl/rxf_addr_shift.sv
module rxf_addr_shift #(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_W     = 6,
  localparam int AW        = 8 * ADDR_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              first,
  input  logic [7:0]        data,
  output logic [AW-1:0]     addr_nxt,
  output logic [HASH_W-1:0] hash_idx
);
  import rxf_pkg::*;

  logic [AW-1:0] addr_q;
  logic [31:0]   crc_q;
  logic [31:0]   crc_nxt;

  assign addr_nxt = first ? AW'(data) : {addr_q[AW-9:0], data};
  assign crc_nxt  = crc_step_byte(first ? 32'hFFFF_FFFF : crc_q, data);
  assign hash_idx = crc_nxt[31 -: HASH_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      crc_q  <= '1;
    end else if (shift_en) begin
      addr_q <= addr_nxt;
      crc_q  <= crc_nxt;
    end
  end
endmodule

// File: rtl/rxf_match.sv
module rxf_match #(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_W     = 6,
  localparam int AW        = 8 * ADDR_BYTES,
  localparam int TBL       = 1 << HASH_W
) (
  input  logic [AW-1:0]     addr,
  input  logic [HASH_W-1:0] hash_idx,
  input  logic              cfg_promisc,
  input  logic              cfg_bcast_reject,
  input  logic [AW-1:0]     cfg_unit_addr,
  input  logic [TBL-1:0]    cfg_uni_hash,
  input  logic [TBL-1:0]    cfg_grp_hash,
  output logic              accept
);
  import rxf_pkg::*;

  addr_kind_e kind;

  always_comb begin
    if (&addr)               kind = KIND_BCAST;
    else if (addr[AW-8])     kind = KIND_GRP;  // lsb of first byte
    else                     kind = KIND_UNI;
  end

  always_comb begin
    if (cfg_promisc) accept = 1'b1;
    else begin
      unique case (kind)
        KIND_BCAST: accept = ~cfg_bcast_reject;
        KIND_GRP:   accept = cfg_grp_hash[hash_idx];
        default:    accept = (addr == cfg_unit_addr) | cfg_uni_hash[hash_idx];
      endcase
    end
  end
endmodule

// File: rtl/rx_dst_filter.sv
module rx_dst_filter #(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_W     = 6,
  parameter int MIN_LEN    = 64,
  localparam int AW        = 8 * ADDR_BYTES,
  localparam int TBL       = 1 << HASH_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [7:0]     in_data,
  input  logic           in_sof,
  input  logic           in_eof,
  input  logic           cfg_promisc,
  input  logic           cfg_bcast_reject,
  input  logic [AW-1:0]  cfg_unit_addr,
  input  logic [TBL-1:0] cfg_uni_hash,
  input  logic [TBL-1:0] cfg_grp_hash,
  output logic           dec_valid,
  output logic           dec_accept,
  output logic           flush
);
  logic              take, first, addr_beat, last_addr_beat, runt_end;
  logic [AW-1:0]     addr_nxt;
  logic [HASH_W-1:0] hash_idx;
  logic              acc_now, acc_final;
  logic              dec_valid_q, dec_accept_q, flush_q;

  rxf_beat_track #(.ADDR_BYTES(ADDR_BYTES), .MIN_LEN(MIN_LEN)) u_track (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
    .take(take), .first(first), .addr_beat(addr_beat),
    .last_addr_beat(last_addr_beat), .runt_end(runt_end)
  );

  rxf_addr_shift #(.ADDR_BYTES(ADDR_BYTES), .HASH_W(HASH_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .shift_en(addr_beat), .first(first), .data(in_data),
    .addr_nxt(addr_nxt), .hash_idx(hash_idx)
  );

  rxf_match #(.ADDR_BYTES(ADDR_BYTES), .HASH_W(HASH_W)) u_match (
    .addr(addr_nxt), .hash_idx(hash_idx), .cfg_promisc(cfg_promisc),
    .cfg_bcast_reject(cfg_bcast_reject), .cfg_unit_addr(cfg_unit_addr),
    .cfg_uni_hash(cfg_uni_hash), .cfg_grp_hash(cfg_grp_hash), .accept(acc_now)
  );

  // decision for a frame that ends on this beat
  assign acc_final = last_addr_beat ? acc_now : dec_accept_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid_q  <= 1'b0;
      dec_accept_q <= 1'b0;
      flush_q      <= 1'b0;
    end else begin
      flush_q <= take & in_eof & (runt_end | ~acc_final);
      if (first) begin
        dec_valid_q  <= 1'b0;
        dec_accept_q <= 1'b0;
      end
      if (last_addr_beat) begin
        dec_valid_q  <= 1'b1;
        dec_accept_q <= acc_now;
      end
    end
  end

  assign in_ready   = 1'b1;
  assign dec_valid  = dec_valid_q;
  assign dec_accept = dec_accept_q;
  assign flush      = flush_q;
endmodule

// File: rtl/rxf_checker.sv
module rxf_checker #(
  parameter int ADDR_BYTES = 6,
  parameter int MIN_LEN    = 64,
  localparam int AW        = 8 * ADDR_BYTES,
  localparam int CW        = $clog2(MIN_LEN + 1)
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic [7:0] in_data,
  input logic       in_sof,
  input logic       in_eof,
  input logic       cfg_promisc,
  input logic       cfg_bcast_reject,
  input logic       dec_valid,
  input logic       dec_accept,
  input logic       flush
);
  logic          ck_in;
  logic [CW-1:0] ck_cnt, ck_pos, ck_len;
  logic [AW-1:0] ck_addr, ck_addr_nxt;
  logic          ck_take, ck_sixth;

  assign ck_take     = in_valid & (in_sof | ck_in);
  assign ck_pos      = in_sof ? '0 : ck_cnt;
  assign ck_len      = in_sof ? CW'(1) : (ck_cnt == CW'(MIN_LEN) ? ck_cnt : ck_cnt + CW'(1));
  assign ck_sixth    = ck_take & (ck_pos == CW'(ADDR_BYTES - 1));
  assign ck_addr_nxt = {ck_addr[AW-9:0], in_data};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_in   <= 1'b0;
      ck_cnt  <= '0;
      ck_addr <= '0;
    end else if (ck_take) begin
      ck_in  <= ~in_eof;
      ck_cnt <= ck_len;
      if (ck_pos < CW'(ADDR_BYTES)) ck_addr <= ck_addr_nxt;
    end
  end

  // R8: decision appears exactly one clock after the sixth byte
  a_r8_dec_after_sixth: assert property (@(posedge clk) disable iff (!rst_n)
    ck_sixth |=> dec_valid);
  a_r8_rise_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dec_valid) |-> $past(ck_sixth));
  // R8: decision holds until the next start beat
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !(ck_take && in_sof)) |=> (dec_valid && $stable(dec_accept)));
  // R7: promiscuous mode accepts
  a_r7_promisc: assert property (@(posedge clk) disable iff (!rst_n)
    (ck_sixth && cfg_promisc) |=> dec_accept);
  // R3: broadcast refused under the reject policy
  a_r3_bcast_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (ck_sixth && cfg_bcast_reject && !cfg_promisc && (&ck_addr_nxt)) |=> !dec_accept);
  // R10: short frames are flushed
  a_r10_runt_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (ck_take && in_eof && (ck_len < CW'(MIN_LEN))) |=> flush);
  // R9: flush only after an end beat inside a frame
  a_r9_flush_source: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> $past(ck_take && in_eof));
endmodule

bind rx_dst_filter rxf_checker #(.ADDR_BYTES(ADDR_BYTES), .MIN_LEN(MIN_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof),
  .in_eof(in_eof), .cfg_promisc(cfg_promisc), .cfg_bcast_reject(cfg_bcast_reject),
  .dec_valid(dec_valid), .dec_accept(dec_accept), .flush(flush)
);

// File: tb/sim_rx_dst_filter.sv
`timescale 1ns/1ps
module sim_rx_dst_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_ready;
  logic        cfg_promisc = 1'b0, cfg_bcast_reject = 1'b0;
  logic [47:0] cfg_unit_addr = 48'h02_11_22_33_44_55;
  logic [63:0] cfg_uni_hash = '0, cfg_grp_hash = '0;
  logic        dec_valid, dec_accept, flush;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  typedef struct { bit has_dec; bit acc; bit fl; string rq; } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  rx_dst_filter u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof), .cfg_promisc(cfg_promisc),
    .cfg_bcast_reject(cfg_bcast_reject), .cfg_unit_addr(cfg_unit_addr),
    .cfg_uni_hash(cfg_uni_hash), .cfg_grp_hash(cfg_grp_hash),
    .dec_valid(dec_valid), .dec_accept(dec_accept), .flush(flush)
  );

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", rq, act, exp, $time);
    end
  endtask

  function automatic logic [5:0] hidx(input logic [47:0] a);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int b = 5; b >= 0; b--) begin
      c = c ^ {24'h0, a[8*b +: 8]};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return c[31:26];
  endfunction

  function automatic bit exp_acc(input logic [47:0] a);
    if (cfg_promisc) return 1'b1;
    if (a == '1) return !cfg_bcast_reject;
    if (a[40]) return cfg_grp_hash[hidx(a)];
    return (a == cfg_unit_addr) || cfg_uni_hash[hidx(a)];
  endfunction

  // driver: pushes the expectation, then sends the frame (no trailing idle)
  task automatic send(input logic [47:0] a, input int len, input string rq);
    exp_t e;
    e.has_dec = (len >= 6);
    e.acc     = e.has_dec ? exp_acc(a) : 1'b0;
    e.fl      = (len < 64) || !e.acc;
    e.rq      = rq;
    q.push_back(e);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = (i < 6) ? a[8*(5-i) +: 8] : 8'(i * 7);
      in_sof   = (i == 0);
      in_eof   = (i == len - 1);
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // monitor
  bit mon_in = 1'b0, chk_dec = 1'b0, chk_end = 1'b0;
  int mon_cnt = 0;
  always @(posedge clk) begin
    if (rst_n && in_valid) begin
      if (in_sof) begin mon_in = 1'b1; mon_cnt = 1; end
      else if (mon_in) mon_cnt++;
      if (mon_in && mon_cnt == 6) chk_dec = 1'b1;
      if (mon_in && in_eof) begin chk_end = 1'b1; mon_in = 1'b0; end
    end
  end

  always @(negedge clk) begin
    if (chk_dec) begin
      chk_dec = 1'b0;
      if (q.size() > 0) begin
        check(dec_valid === 1'b1, {q[0].rq, " R8 dec_valid"}, dec_valid, 1);
        check(dec_accept === q[0].acc, {q[0].rq, " accept"}, dec_accept, q[0].acc);
      end
    end
    if (chk_end) begin
      exp_t e;
      chk_end = 1'b0;
      if (q.size() == 0) check(1'b0, "R9 no expectation", 1, 0);
      else begin
        e = q.pop_front();
        check(flush === e.fl, {e.rq, " R9 flush"}, flush, e.fl);
        check(dec_valid === e.has_dec, {e.rq, " R8 held valid"}, dec_valid, e.has_dec);
        if (e.has_dec) check(dec_accept === e.acc, {e.rq, " R8 held accept"}, dec_accept, e.acc);
      end
    end else if (rst_n && flush === 1'b1) begin
      check(1'b0, "R1 R9 unexpected flush", 1, 0);
    end
  end

  logic [47:0] ua, ma;
  initial begin
    ua = 48'h04_AA_BB_CC_DD_EE;   // individual, not own address
    ma = 48'h01_00_5E_10_20_30;   // group
    repeat (4) @(negedge clk);
    check(dec_valid === 1'b0 && flush === 1'b0, "R8 reset outputs", {dec_valid, flush}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready === 1'b1, "R1 ready high", in_ready, 1);

    send(cfg_unit_addr, 64, "R4 R2 exact match");          idle(2);
    send(ua, 64, "R5 hash empty");                          idle(2);
    cfg_uni_hash = 64'h1 << hidx(ua);
    send(ua, 70, "R5 R11 hash bit set");                    idle(2);
    cfg_uni_hash = ~(64'h1 << hidx(ua));
    send(ua, 64, "R5 R11 other bits only");                 idle(2);
    cfg_grp_hash = 64'h1 << hidx(ma); cfg_uni_hash = '0;
    send(ma, 64, "R6 group hash set");                      idle(2);
    cfg_grp_hash = '0; cfg_uni_hash = '1;
    send(ma, 64, "R6 R2 group ignores unicast table");      idle(2);
    cfg_uni_hash = '0;
    send(48'hFFFF_FFFF_FFFF, 64, "R3 broadcast accept");    idle(2);
    cfg_bcast_reject = 1'b1; cfg_grp_hash = '1;
    send(48'hFFFF_FFFF_FFFF, 64, "R3 broadcast reject");    idle(2);
    cfg_promisc = 1'b1;
    send(48'hFFFF_FFFF_FFFF, 64, "R7 promisc broadcast");   idle(1);
    send(ua, 64, "R7 promisc unicast");                     idle(2);
    cfg_promisc = 1'b0; cfg_grp_hash = '0;
    send(cfg_unit_addr, 63, "R10 runt 63");
    send(cfg_unit_addr, 64, "R10 length 64 back to back");
    send(cfg_unit_addr, 40, "R10 accepted runt");           idle(2);
    send(cfg_unit_addr, 4, "R10 no decision short");        idle(2);
    send(cfg_unit_addr, 1, "R10 single byte");              idle(2);
    send(cfg_unit_addr, 64, "R1 frame before junk");        idle(3);
    // junk outside any frame
    for (int j = 0; j < 8; j++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sof = 1'b0; in_eof = (j % 3 == 0); in_data = 8'hFF;
    end
    idle(2);
    check(dec_valid === 1'b1 && dec_accept === 1'b1, "R1 junk ignored", {dec_valid, dec_accept}, 3);
    send(ua, 64, "R1 frame after junk");                    idle(4);
    check(q.size() == 0, "R9 all frames resolved", q.size(), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual 0 expected 1 (run ended)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule